// File: doc/BRIEF.md
# Banked Dual-Port Synchronous RAM

This block is a shared memory reached from two independent request ports, A and B. The storage is not one true two-port array. It is a row of single-port banks. On every request a port names a bank with its bank-select inputs and a word inside that bank with its word-address inputs. The bank is routed to that port for the cycle. Both ports can work at once as long as they name different banks. When they name the same bank in the same cycle, both accesses are void: writes are dropped, reads come back flagged as bad, and each port raises its conflict output.

Each port registers its request on the rising clock edge: select pair, write strobe, output enable, byte enables, bank, word and write data. The 18-bit word is split into two 9-bit lanes, and each lane can be written on its own. Read data comes out either straight from the first output register (flow-through) or through one more register (pipelined), as chosen by a per-port mode pin. The output enable gates only the valid flag.

Each port has an access-state register with five states: `ACC_IDLE`, `ACC_READ`, `ACC_WRITE`, `ACC_RD_BAD` and `ACC_WR_LOST`. At each edge the state moves to the value computed from the registered request. An unselected port goes to `ACC_IDLE`. A clashing read goes to `ACC_RD_BAD` and a clashing write to `ACC_WR_LOST`. Any other request goes to `ACC_WRITE` or `ACC_READ`. Any state can move to any other on the next edge. Pipelined mode keeps a second, delayed copy of this state.

The full-size part uses `BANK_AW=6` and `WORD_AW=13`, which gives 64 banks of 8K words. The defaults are smaller so that simulation stays light.

Top module: `bsw_dpram`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_valid`, `rd_err` and `conflict` are 0 on both ports until a read is requested.
- R2: In flow-through mode (`pipe`=0) a read captured at edge N shows `rd_data` equal to the stored word, `rd_valid`=1 and `rd_err`=0 after edge N+1.
- R3: `be[0]` enables the lower lane, bits [8:0], and `be[1]` enables the upper lane, bits [17:9]. A lane whose enable is 0 keeps its old contents. When `be`=00 the write changes nothing.
- R4: A port is selected only when `cs_n`=0 and `cs`=1. An unselected port writes nothing, never raises `rd_valid`, and never causes a conflict.
- R5: In pipelined mode (`pipe`=1) read results appear after edge N+2, and after edge N+1 `rd_valid` is still 0.
- R6: When `oe`=0 on a read, `rd_valid` stays 0 but `rd_data` still carries the stored word at the normal latency.
- R7: Two selected ports that name different banks in the same cycle both complete their accesses, and no conflict is raised.
- R8: When both ports are selected and name the same bank, `conflict` is 1 on both ports between edge N and edge N+1. Both writes are dropped. Reads give `rd_valid`=0 and `rd_err`=1 at their normal latency.
- R9: A write captured at edge N is seen by a read captured at edge N+1 to the same word.
- R10: Either port can read any bank, including words the other port wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_cs_n | input | 1 | Port A select, active low |
| pa_cs | input | 1 | Port A select, active high |
| pa_we | input | 1 | Port A write (1) or read (0) |
| pa_oe | input | 1 | Port A read-valid enable |
| pa_pipe | input | 1 | Port A output mode: 1 pipelined, 0 flow-through |
| pa_be | input | 2 | Port A lane enables, bit 0 lower, bit 1 upper |
| pa_bank | input | BANK_AW | Port A bank select |
| pa_word | input | WORD_AW | Port A word address in bank |
| pa_wdata | input | WORD_W | Port A write data |
| pa_rdata | output | WORD_W | Port A read data |
| pa_rd_valid | output | 1 | Port A read data valid |
| pa_rd_err | output | 1 | Port A read voided by bank clash |
| pa_conflict | output | 1 | Port A registered request clashes with port B |
| pb_cs_n | input | 1 | Port B select, active low |
| pb_cs | input | 1 | Port B select, active high |
| pb_we | input | 1 | Port B write (1) or read (0) |
| pb_oe | input | 1 | Port B read-valid enable |
| pb_pipe | input | 1 | Port B output mode: 1 pipelined, 0 flow-through |
| pb_be | input | 2 | Port B lane enables, bit 0 lower, bit 1 upper |
| pb_bank | input | BANK_AW | Port B bank select |
| pb_word | input | WORD_AW | Port B word address in bank |
| pb_wdata | input | WORD_W | Port B write data |
| pb_rdata | output | WORD_W | Port B read data |
| pb_rd_valid | output | 1 | Port B read data valid |
| pb_rd_err | output | 1 | Port B read voided by bank clash |
| pb_conflict | output | 1 | Port B registered request clashes with port A |

## Verification
Two functions can fall in the same cycle: a normal access on each port, and detection of a clash between them. The bench provokes this by driving both ports in one cycle. It does this once with different banks, to show that both accesses complete, and once with the same bank under both writes and reads, to show that the accesses are voided. A clash is judged by sampling both conflict flags in the cycle after capture. Each port then reads its word back alone to prove the write was dropped. For the clashing reads, the bench checks `rd_err` and `rd_valid` at the flow-through latency. A same-bank request from an unselected port is also issued, to show that it cannot raise a clash.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;
    // Access state carried with each registered request down the output path
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_READ    = 3'd1,
        ACC_WRITE   = 3'd2,
        ACC_RD_BAD  = 3'd3,
        ACC_WR_LOST = 3'd4
    } acc_e;

    localparam int LANES = 2;
endpackage

// File: rtl/bsw_port_in.sv
`timescale 1ns/1ps
module bsw_port_in #(
    parameter int BANK_AW = 3,
    parameter int WORD_AW = 4,
    parameter int WORD_W  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               cs,
    input  logic               we,
    input  logic               oe,
    input  logic [1:0]         be,
    input  logic [BANK_AW-1:0] bank,
    input  logic [WORD_AW-1:0] word,
    input  logic [WORD_W-1:0]  wdata,
    output logic               sel_q,
    output logic               we_q,
    output logic               oe_q,
    output logic [1:0]         be_q,
    output logic [BANK_AW-1:0] bank_q,
    output logic [WORD_AW-1:0] word_q,
    output logic [WORD_W-1:0]  wdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            we_q    <= 1'b0;
            oe_q    <= 1'b0;
            be_q    <= '0;
            bank_q  <= '0;
            word_q  <= '0;
            wdata_q <= '0;
        end else begin
            sel_q   <= !cs_n && cs;
            we_q    <= we;
            oe_q    <= oe;
            be_q    <= be;
            bank_q  <= bank;
            word_q  <= word;
            wdata_q <= wdata;
        end
    end

    // R4
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n || !cs) |-> !sel_q);
endmodule

// File: rtl/bsw_bank.sv
`timescale 1ns/1ps
module bsw_bank #(
    parameter int WORD_AW = 4,
    parameter int WORD_W  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               we,
    input  logic [1:0]         be,
    input  logic [WORD_AW-1:0] word,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata
);
    localparam int DEPTH  = 1 << WORD_AW;
    localparam int BYTE_W = WORD_W / bsw_pkg::LANES;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int l = 0; l < bsw_pkg::LANES; l++) begin
                if (be[l]) mem[word][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem[word];

    // R3
    lane_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we && !be[0]) |=> (mem[$past(word)][BYTE_W-1:0] == $past(rdata[BYTE_W-1:0])));
    // R3
    lane_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we && !be[1]) |=> (mem[$past(word)][WORD_W-1:BYTE_W] == $past(rdata[WORD_W-1:BYTE_W])));
endmodule

// File: rtl/bsw_port_out.sv
`timescale 1ns/1ps
module bsw_port_out #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              oe,
    input  logic              clash,
    input  logic              pipe,
    input  logic [WORD_W-1:0] bank_rd,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid,
    output logic              rd_err
);
    import bsw_pkg::*;

    acc_e              st1_q, st2_q, st_next, st_out;
    logic [WORD_W-1:0] d1_q, d2_q;
    logic              oe1_q, oe2_q, oe_out;

    always_comb begin
        if (!sel)       st_next = ACC_IDLE;
        else if (clash) st_next = we ? ACC_WR_LOST : ACC_RD_BAD;
        else            st_next = we ? ACC_WRITE : ACC_READ;
    end

    // state register: flow stage then pipeline stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= ACC_IDLE;
            st2_q <= ACC_IDLE;
            d1_q  <= '0;
            d2_q  <= '0;
            oe1_q <= 1'b0;
            oe2_q <= 1'b0;
        end else begin
            st1_q <= st_next;
            d1_q  <= bank_rd;
            oe1_q <= oe;
            st2_q <= st1_q;
            d2_q  <= d1_q;
            oe2_q <= oe1_q;
        end
    end

    // output process
    always_comb begin
        st_out   = pipe ? st2_q : st1_q;
        oe_out   = pipe ? oe2_q : oe1_q;
        rdata    = pipe ? d2_q  : d1_q;
        rd_valid = 1'b0;
        rd_err   = 1'b0;
        unique case (st_out)
            ACC_READ:    rd_valid = oe_out;
            ACC_RD_BAD:  rd_err   = 1'b1;
            ACC_IDLE,
            ACC_WRITE,
            ACC_WR_LOST: ;
            default:     ;
        endcase
    end

    // R2
    flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(!pipe) && $past(sel && !we && !clash && oe)) |-> rd_valid);
    // R5
    pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && $past(pipe) && $past(pipe, 2) && $past(sel && !we && !clash && oe, 2)) |-> rd_valid);
    // R8
    bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(!pipe) && $past(sel && !we && clash)) |-> (rd_err && !rd_valid));
    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(!pipe) && $past(!oe)) |-> !rd_valid);
endmodule

// File: rtl/bsw_dpram.sv
`timescale 1ns/1ps
module bsw_dpram #(
    parameter int BANK_AW = 3,
    parameter int WORD_AW = 4,
    parameter int WORD_W  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pa_cs_n,
    input  logic               pa_cs,
    input  logic               pa_we,
    input  logic               pa_oe,
    input  logic               pa_pipe,
    input  logic [1:0]         pa_be,
    input  logic [BANK_AW-1:0] pa_bank,
    input  logic [WORD_AW-1:0] pa_word,
    input  logic [WORD_W-1:0]  pa_wdata,
    output logic [WORD_W-1:0]  pa_rdata,
    output logic               pa_rd_valid,
    output logic               pa_rd_err,
    output logic               pa_conflict,
    input  logic               pb_cs_n,
    input  logic               pb_cs,
    input  logic               pb_we,
    input  logic               pb_oe,
    input  logic               pb_pipe,
    input  logic [1:0]         pb_be,
    input  logic [BANK_AW-1:0] pb_bank,
    input  logic [WORD_AW-1:0] pb_word,
    input  logic [WORD_W-1:0]  pb_wdata,
    output logic [WORD_W-1:0]  pb_rdata,
    output logic               pb_rd_valid,
    output logic               pb_rd_err,
    output logic               pb_conflict
);
    localparam int NBANK = 1 << BANK_AW;

    logic               a_sel, a_we, a_oe, b_sel, b_we, b_oe;
    logic [1:0]         a_be, b_be;
    logic [BANK_AW-1:0] a_bank, b_bank;
    logic [WORD_AW-1:0] a_word, b_word;
    logic [WORD_W-1:0]  a_wd, b_wd;
    logic               clash;
    logic [NBANK-1:0]   own_a, own_b;
    logic [WORD_W-1:0]  bank_rd [NBANK];

    bsw_port_in #(.BANK_AW(BANK_AW), .WORD_AW(WORD_AW), .WORD_W(WORD_W)) in_a (
        .clk(clk), .rst_n(rst_n), .cs_n(pa_cs_n), .cs(pa_cs), .we(pa_we), .oe(pa_oe),
        .be(pa_be), .bank(pa_bank), .word(pa_word), .wdata(pa_wdata),
        .sel_q(a_sel), .we_q(a_we), .oe_q(a_oe), .be_q(a_be), .bank_q(a_bank),
        .word_q(a_word), .wdata_q(a_wd));

    bsw_port_in #(.BANK_AW(BANK_AW), .WORD_AW(WORD_AW), .WORD_W(WORD_W)) in_b (
        .clk(clk), .rst_n(rst_n), .cs_n(pb_cs_n), .cs(pb_cs), .we(pb_we), .oe(pb_oe),
        .be(pb_be), .bank(pb_bank), .word(pb_word), .wdata(pb_wdata),
        .sel_q(b_sel), .we_q(b_we), .oe_q(b_oe), .be_q(b_be), .bank_q(b_bank),
        .word_q(b_word), .wdata_q(b_wd));

    assign clash       = a_sel && b_sel && (a_bank == b_bank);
    assign pa_conflict = clash;
    assign pb_conflict = clash;

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic bk_en, bk_we;
        logic [1:0] bk_be;
        logic [WORD_AW-1:0] bk_word;
        logic [WORD_W-1:0] bk_wd;

        assign own_a[i] = a_sel && !clash && (a_bank == BANK_AW'(i));
        assign own_b[i] = b_sel && !clash && (b_bank == BANK_AW'(i));
        assign bk_en    = own_a[i] || own_b[i];
        assign bk_we    = own_a[i] ? a_we   : b_we;
        assign bk_be    = own_a[i] ? a_be   : b_be;
        assign bk_word  = own_a[i] ? a_word : b_word;
        assign bk_wd    = own_a[i] ? a_wd   : b_wd;

        bsw_bank #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .en(bk_en), .we(bk_we), .be(bk_be),
            .word(bk_word), .wdata(bk_wd), .rdata(bank_rd[i]));
    end

    bsw_port_out #(.WORD_W(WORD_W)) out_a (
        .clk(clk), .rst_n(rst_n), .sel(a_sel), .we(a_we), .oe(a_oe), .clash(clash),
        .pipe(pa_pipe), .bank_rd(bank_rd[a_bank]), .rdata(pa_rdata),
        .rd_valid(pa_rd_valid), .rd_err(pa_rd_err));

    bsw_port_out #(.WORD_W(WORD_W)) out_b (
        .clk(clk), .rst_n(rst_n), .sel(b_sel), .we(b_we), .oe(b_oe), .clash(clash),
        .pipe(pb_pipe), .bank_rd(bank_rd[b_bank]), .rdata(pb_rdata),
        .rd_valid(pb_rd_valid), .rd_err(pb_rd_err));

    // R8
    clash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa_conflict |-> (own_a == '0 && own_b == '0));
    // R7
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(own_a) && $onehot0(own_b) && ((own_a & own_b) == '0)));
    // R4
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sel || !b_sel) |-> !pb_conflict);
endmodule

// File: tb/bsw_dpram_tb_top.sv
`timescale 1ns/1ps
module bsw_dpram_tb_top;
    localparam int BAW = 3;
    localparam int WAW = 4;
    localparam int DW  = 18;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic pa_cs_n, pa_cs, pa_we, pa_oe, pa_pipe, pb_cs_n, pb_cs, pb_we, pb_oe, pb_pipe;
    logic [1:0] pa_be, pb_be;
    logic [BAW-1:0] pa_bank, pb_bank;
    logic [WAW-1:0] pa_word, pb_word;
    logic [DW-1:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;
    logic pa_rd_valid, pa_rd_err, pa_conflict, pb_rd_valid, pb_rd_err, pb_conflict;

    bsw_dpram #(.BANK_AW(BAW), .WORD_AW(WAW), .WORD_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pa_cs_n(pa_cs_n), .pa_cs(pa_cs), .pa_we(pa_we), .pa_oe(pa_oe), .pa_pipe(pa_pipe),
        .pa_be(pa_be), .pa_bank(pa_bank), .pa_word(pa_word), .pa_wdata(pa_wdata),
        .pa_rdata(pa_rdata), .pa_rd_valid(pa_rd_valid), .pa_rd_err(pa_rd_err),
        .pa_conflict(pa_conflict),
        .pb_cs_n(pb_cs_n), .pb_cs(pb_cs), .pb_we(pb_we), .pb_oe(pb_oe), .pb_pipe(pb_pipe),
        .pb_be(pb_be), .pb_bank(pb_bank), .pb_word(pb_word), .pb_wdata(pb_wdata),
        .pb_rdata(pb_rdata), .pb_rd_valid(pb_rd_valid), .pb_rd_err(pb_rd_err),
        .pb_conflict(pb_conflict));

    typedef struct packed {
        logic cs_n; logic cs; logic we; logic oe;
        logic [1:0] be; logic [BAW-1:0] bank; logic [WAW-1:0] word; logic [DW-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic rd; logic pb; logic [BAW-1:0] bank; logic [WAW-1:0] word;
        logic [1:0] be; logic [DW-1:0] data;
    } vec_t;

    // rd=1 entries expect data; covers R2, R3 (lanes), R10 (cross-port)
    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 3'd0, 4'd1,  2'b11, 18'h2A5A5},
        '{1'b1, 1'b0, 3'd0, 4'd1,  2'b00, 18'h2A5A5},
        '{1'b0, 1'b1, 3'd5, 4'd15, 2'b11, 18'h1C3C3},
        '{1'b1, 1'b0, 3'd5, 4'd15, 2'b00, 18'h1C3C3},
        '{1'b1, 1'b1, 3'd0, 4'd1,  2'b00, 18'h2A5A5},
        '{1'b0, 1'b0, 3'd7, 4'd0,  2'b11, 18'h3FFFF},
        '{1'b0, 1'b0, 3'd7, 4'd0,  2'b01, 18'h00000},
        '{1'b1, 1'b1, 3'd7, 4'd0,  2'b00, 18'h3FE00},
        '{1'b0, 1'b1, 3'd7, 4'd0,  2'b10, 18'h2AAAA},
        '{1'b1, 1'b0, 3'd7, 4'd0,  2'b00, 18'h2AA00},
        '{1'b0, 1'b0, 3'd3, 4'd8,  2'b11, 18'h12345},
        '{1'b0, 1'b1, 3'd3, 4'd8,  2'b00, 18'h3FFFF},
        '{1'b1, 1'b0, 3'd3, 4'd8,  2'b00, 18'h12345}
    };

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic conf_a_s, conf_b_s;

    function automatic req_t mk(logic cs_n, logic cs, logic we, logic oe, logic [1:0] be,
                                logic [BAW-1:0] bank, logic [WAW-1:0] word, logic [DW-1:0] d);
        return '{cs_n: cs_n, cs: cs, we: we, oe: oe, be: be, bank: bank, word: word, wdata: d};
    endfunction
    function automatic req_t wrq(logic [BAW-1:0] b, logic [WAW-1:0] w, logic [1:0] be, logic [DW-1:0] d);
        return mk(1'b0, 1'b1, 1'b1, 1'b1, be, b, w, d);
    endfunction
    function automatic req_t rdq(logic [BAW-1:0] b, logic [WAW-1:0] w, logic oe);
        return mk(1'b0, 1'b1, 1'b0, oe, 2'b00, b, w, '0);
    endfunction
    localparam req_t NOP = '{cs_n: 1'b1, cs: 1'b0, we: 1'b0, oe: 1'b0, be: 2'b00,
                             bank: '0, word: '0, wdata: '0};

    task automatic set_ports(input req_t a, input req_t b);
        pa_cs_n = a.cs_n; pa_cs = a.cs; pa_we = a.we; pa_oe = a.oe; pa_be = a.be;
        pa_bank = a.bank; pa_word = a.word; pa_wdata = a.wdata;
        pb_cs_n = b.cs_n; pb_cs = b.cs; pb_we = b.we; pb_oe = b.oe; pb_be = b.be;
        pb_bank = b.bank; pb_word = b.word; pb_wdata = b.wdata;
    endtask

    // called at a falling edge; returns at the falling edge after the capture edge
    task automatic apply(input req_t a, input req_t b);
        set_ports(a, b);
        @(posedge clk);
        @(negedge clk);
        conf_a_s = pa_conflict;
        conf_b_s = pb_conflict;
        set_ports(NOP, NOP);
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pa_pipe = 1'b0;
        pb_pipe = 1'b0;
        set_ports(NOP, NOP);
        repeat (3) @(negedge clk);
        chk("R1 valid_a in reset", DW'(pa_rd_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid_a", DW'(pa_rd_valid), '0);
        chk("R1 valid_b", DW'(pb_rd_valid), '0);
        chk("R1 err", DW'({pa_rd_err, pb_rd_err}), '0);
        chk("R1 conflict", DW'({pa_conflict, pb_conflict}), '0);

        // table walk: R2 R3 R10
        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                if (VT[i].pb) apply(NOP, rdq(VT[i].bank, VT[i].word, 1'b1));
                else          apply(rdq(VT[i].bank, VT[i].word, 1'b1), NOP);
                @(negedge clk);
                chk("R2 R3 R10 table valid", DW'(VT[i].pb ? pb_rd_valid : pa_rd_valid), DW'(1));
                chk("R2 table err", DW'(VT[i].pb ? pb_rd_err : pa_rd_err), '0);
                chk("R2 R3 R10 table data", VT[i].pb ? pb_rdata : pa_rdata, VT[i].data);
            end else begin
                if (VT[i].pb) apply(NOP, wrq(VT[i].bank, VT[i].word, VT[i].be, VT[i].data));
                else          apply(wrq(VT[i].bank, VT[i].word, VT[i].be, VT[i].data), NOP);
            end
        end

        // R4: unselected writes (both inactive encodings) leave the word alone
        apply(mk(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 3'd3, 4'd8, 18'h00000), NOP);
        apply(mk(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 3'd3, 4'd8, 18'h00000), NOP);
        apply(mk(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 3'd3, 4'd8, 18'h00000), NOP);
        @(negedge clk);
        chk("R4 unselected read valid", DW'(pa_rd_valid), '0);
        apply(rdq(3'd3, 4'd8, 1'b1), NOP);
        @(negedge clk);
        chk("R4 word kept", pa_rdata, 18'h12345);

        // R5: pipelined latency
        pa_pipe = 1'b1;
        apply(rdq(3'd0, 4'd1, 1'b1), NOP);
        @(negedge clk);
        chk("R5 not yet valid", DW'(pa_rd_valid), '0);
        @(negedge clk);
        chk("R5 valid", DW'(pa_rd_valid), DW'(1));
        chk("R5 data", pa_rdata, 18'h2A5A5);
        pa_pipe = 1'b0;
        @(negedge clk);

        // R6: output enable gates only valid
        apply(NOP, rdq(3'd5, 4'd15, 1'b0));
        @(negedge clk);
        chk("R6 valid gated", DW'(pb_rd_valid), '0);
        chk("R6 data present", pb_rdata, 18'h1C3C3);

        // R7: both ports, different banks, same cycle
        apply(wrq(3'd1, 4'd2, 2'b11, 18'h11111), wrq(3'd2, 4'd2, 2'b11, 18'h22222));
        chk("R7 no conflict on writes", DW'({conf_a_s, conf_b_s}), '0);
        apply(rdq(3'd2, 4'd2, 1'b1), rdq(3'd1, 4'd2, 1'b1));
        @(negedge clk);
        chk("R7 R10 data a", pa_rdata, 18'h22222);
        chk("R7 R10 data b", pb_rdata, 18'h11111);
        chk("R7 valid both", DW'({pa_rd_valid, pb_rd_valid}), DW'(3));

        // R9: write then read on the next cycle
        apply(wrq(3'd6, 4'd9, 2'b11, 18'h0F0F0), NOP);
        apply(rdq(3'd6, 4'd9, 1'b1), NOP);
        @(negedge clk);
        chk("R9 fresh data", pa_rdata, 18'h0F0F0);

        // R8: same-bank clash
        apply(wrq(3'd4, 4'd3, 2'b11, 18'h0ABCD), NOP);
        apply(NOP, wrq(3'd4, 4'd5, 2'b11, 18'h05555));
        apply(wrq(3'd4, 4'd3, 2'b11, 18'h3FFFF), wrq(3'd4, 4'd5, 2'b11, 18'h3FFFF));
        chk("R8 conflict on write clash", DW'({conf_a_s, conf_b_s}), DW'(3));
        apply(rdq(3'd4, 4'd3, 1'b1), NOP);
        @(negedge clk);
        chk("R8 write a dropped", pa_rdata, 18'h0ABCD);
        apply(NOP, rdq(3'd4, 4'd5, 1'b1));
        @(negedge clk);
        chk("R8 write b dropped", pb_rdata, 18'h05555);
        apply(rdq(3'd4, 4'd3, 1'b1), rdq(3'd4, 4'd5, 1'b1));
        chk("R8 conflict on read clash", DW'({conf_a_s, conf_b_s}), DW'(3));
        @(negedge clk);
        chk("R8 read flags a", DW'({pa_rd_valid, pa_rd_err}), DW'(1));
        chk("R8 read flags b", DW'({pb_rd_valid, pb_rd_err}), DW'(1));

        // R4 with R8: unselected port naming same bank causes no clash
        apply(rdq(3'd4, 4'd3, 1'b1), mk(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 3'd4, 4'd5, '0));
        chk("R4 R8 no conflict", DW'({conf_a_s, conf_b_s}), '0);
        @(negedge clk);
        chk("R4 R8 read a ok", pa_rdata, 18'h0ABCD);
        chk("R4 R8 flags", DW'({pa_rd_valid, pb_rd_valid, pa_rd_err}), DW'(4));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule